// File: doc/BRIEF.md
# HEC Error Performance Counters

This block sits beside the header check of a receive ATM cell path and keeps two performance counts. The first counts cells whose header had a single-bit HEC error. The second counts cells whose header had more than one bit in error. The checker upstream gives one strobe per affected cell. A multi-bit cell gives one increment however many header bits are wrong.

Software reads the two 16-bit counts over a byte-wide synchronous read port. Each count has a high-byte address and a low-byte address. Reading the high byte freezes the full count into a shadow register and clears the live counter. The low-byte read that follows returns the frozen low byte, so both halves describe the same instant. An event that lands on the clearing cycle is kept. Each counter stops at its maximum value instead of wrapping.

Top module: `hec_pmon`

## Requirements
- R1: After reset, every count and shadow value is 0 and `rd_data` is 00h.
- R2: Each cycle with `sb_evt` high and `mb_evt` low adds 1 to the single-bit count. Each cycle with `mb_evt` high adds 1 to the multi-bit count.
- R3: In a cycle where `sb_evt` and `mb_evt` are both high, only the multi-bit count increments. The single-bit count is unchanged.
- R4: The register addresses are: 2Eh for the single-bit high byte, 2Fh for the single-bit low byte, 30h for the multi-bit high byte, and 31h for the multi-bit low byte.
- R5: A high-byte read returns bits 15:8 of the live count. It copies all 16 bits into that counter's shadow and clears the live count. A low-byte read returns bits 7:0 of the shadow and leaves the live count untouched.
- R6: If an event strobe for a counter is high in the same cycle as that counter's high-byte read, the count after the clear is 1.
- R7: A count that reaches FFFFh stays at FFFFh while further events arrive.
- R8: A read of any other address returns 00h and changes no count or shadow.
- R9: `rd_data` is registered. It carries the read result in the cycle after `rd_en` and is 00h in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sb_evt | input | 1 | One-cycle strobe: cell with single-bit header error |
| mb_evt | input | 1 | One-cycle strobe: cell with multi-bit header error |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench goes after the event that arrives on the clearing read. A design that dropped it would read 0 instead of 1 afterwards. It also checks an event that arrives between the high and low reads. A design reading the low byte from the live counter would return a value that does not match the high byte. Both strobes are asserted together to catch a design that counts the cell twice. More than 65535 events are sent to expose a counter that wraps to a small value. Unmapped reads are placed between events to catch a decoder that aliases an address and clears a counter by mistake.

// File: rtl/hec_pmon_pkg.sv
package hec_pmon_pkg;
  localparam int NUM_CTR = 2;
  localparam int CTR_SB  = 0;
  localparam int CTR_MB  = 1;
endpackage

// File: rtl/hec_evt_ctr.sv
module hec_evt_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] shd_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, shd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      shd_q <= '0;
    end else if (snap_i) begin
      shd_q <= cnt_q;
      cnt_q <= {{(CNT_W-1){1'b0}}, inc_i};
    end else if (inc_i && cnt_q != MAX_CNT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign shd_o = shd_q;

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!snap_i && cnt_q == MAX_CNT) |=> cnt_q == MAX_CNT);
  // R6
  clear_keep_evt_chk: assert property (@(posedge clk) disable iff (rst)
    snap_i |=> cnt_q == CNT_W'($past(inc_i)));
  // R5
  shadow_copy_chk: assert property (@(posedge clk) disable iff (rst)
    snap_i |=> shd_q == $past(cnt_q));
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!snap_i && inc_i && cnt_q != MAX_CNT) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!snap_i && !inc_i) |=> ($stable(cnt_q) && $stable(shd_q)));
endmodule

// File: rtl/hec_rd_decode.sv
module hec_rd_decode
  import hec_pmon_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  SB_HI_ADDR = 8'h2E,
  parameter logic [7:0]  SB_LO_ADDR = 8'h2F,
  parameter logic [7:0]  MB_HI_ADDR = 8'h30,
  parameter logic [7:0]  MB_LO_ADDR = 8'h31
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NUM_CTR-1:0] hi_sel,
  output logic [NUM_CTR-1:0] lo_sel
);
  always_comb begin
    hi_sel = '0;
    lo_sel = '0;
    if (rd_en) begin
      hi_sel[CTR_SB] = (rd_addr == ADDR_W'(SB_HI_ADDR));
      lo_sel[CTR_SB] = (rd_addr == ADDR_W'(SB_LO_ADDR));
      hi_sel[CTR_MB] = (rd_addr == ADDR_W'(MB_HI_ADDR));
      lo_sel[CTR_MB] = (rd_addr == ADDR_W'(MB_LO_ADDR));
    end
  end
endmodule

// File: rtl/hec_pmon.sv
module hec_pmon
  import hec_pmon_pkg::*;
#(
  parameter int          BYTE_W     = 8,
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  SB_HI_ADDR = 8'h2E,
  parameter logic [7:0]  SB_LO_ADDR = 8'h2F,
  parameter logic [7:0]  MB_HI_ADDR = 8'h30,
  parameter logic [7:0]  MB_LO_ADDR = 8'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sb_evt,
  input  logic              mb_evt,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [NUM_CTR-1:0] inc, hi_sel, lo_sel;
  logic [CNT_W-1:0]   cnt [NUM_CTR];
  logic [CNT_W-1:0]   shd [NUM_CTR];
  logic [BYTE_W-1:0]  rd_q;

  // multi-bit wins when both strobes are seen
  assign inc[CTR_MB] = mb_evt;
  assign inc[CTR_SB] = sb_evt & ~mb_evt;

  hec_rd_decode #(
    .ADDR_W(ADDR_W), .SB_HI_ADDR(SB_HI_ADDR), .SB_LO_ADDR(SB_LO_ADDR),
    .MB_HI_ADDR(MB_HI_ADDR), .MB_LO_ADDR(MB_LO_ADDR)
  ) u_dec (
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .hi_sel (hi_sel),
    .lo_sel (lo_sel)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    hec_evt_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .inc_i (inc[g]),
      .snap_i(hi_sel[g]),
      .cnt_o (cnt[g]),
      .shd_o (shd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      rd_q <= '0;
      for (int i = 0; i < NUM_CTR; i++) begin
        if (hi_sel[i]) rd_q <= cnt[i][CNT_W-1:BYTE_W];
        if (lo_sel[i]) rd_q <= shd[i][BYTE_W-1:0];
      end
    end
  end

  assign rd_data = rd_q;

  // R3
  both_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (sb_evt && mb_evt && !(rd_en && rd_addr == ADDR_W'(SB_HI_ADDR)))
      |=> cnt[CTR_SB] == $past(cnt[CTR_SB]));
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != ADDR_W'(SB_HI_ADDR) && rd_addr != ADDR_W'(SB_LO_ADDR) &&
     rd_addr != ADDR_W'(MB_HI_ADDR) && rd_addr != ADDR_W'(MB_LO_ADDR))
      |=> rd_data == '0);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0);
  // R5
  hi_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == ADDR_W'(MB_HI_ADDR))
      |=> rd_data == $past(cnt[CTR_MB][CNT_W-1:BYTE_W]));
endmodule

// File: tb/hec_pmon_bench.sv
module hec_pmon_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sb_evt = 1'b0, mb_evt = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h00;
  logic [7:0] rd_data;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hec_pmon u_hec_pmon (
    .clk(clk), .rst(rst), .sb_evt(sb_evt), .mb_evt(mb_evt),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {single-only cycles, multi-only cycles, both-strobe cycles}
  localparam logic [47:0] VEC [6] = '{
    {16'd1,   16'd0,  16'd0},
    {16'd0,   16'd1,  16'd0},
    {16'd7,   16'd3,  16'd0},
    {16'd0,   16'd0,  16'd4},
    {16'd300, 16'd2,  16'd5},
    {16'd12,  16'd260,16'd1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ev(input logic s, input logic m, input int n);
    for (int k = 0; k < n; k++) begin
      sb_evt = s; mb_evt = m;
      @(negedge clk);
    end
    sb_evt = 1'b0; mb_evt = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd16(input logic [7:0] hi_a, output logic [15:0] v);
    logic [7:0] h, l;
    rd(hi_a, h);
    rd(hi_a + 8'd1, l);
    v = {h, l};
  endtask

  initial begin
    logic [7:0]  d;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", {8'h0, rd_data}, 16'h0);
    rd16(8'h2E, v); chk("R1 single count", v, 16'h0);
    rd16(8'h30, v); chk("R1 multi count", v, 16'h0);

    // R2 R3 R4 table walk
    foreach (VEC[i]) begin
      ev(1'b1, 1'b0, int'(VEC[i][47:32]));
      ev(1'b0, 1'b1, int'(VEC[i][31:16]));
      ev(1'b1, 1'b1, int'(VEC[i][15:0]));
      rd16(8'h2E, v); chk("R2/R3 single at 2Eh/2Fh", v, VEC[i][47:32]);
      rd16(8'h30, v); chk("R2/R3 multi at 30h/31h", v, VEC[i][31:16] + VEC[i][15:0]);
    end

    // R9 idle cycle after a read returns 00h
    ev(1'b1, 1'b0, 9);
    rd(8'h2E, d);
    @(negedge clk);
    chk("R9 idle after read", {8'h0, rd_data}, 16'h0);
    rd(8'h2F, d); chk("R9 low byte one cycle later", {8'h0, d}, 16'h9);

    // R8 unmapped addresses
    ev(1'b1, 1'b0, 5);
    ev(1'b0, 1'b1, 2);
    rd(8'h2D, d); chk("R8 2Dh", {8'h0, d}, 16'h0);
    rd(8'h32, d); chk("R8 32h", {8'h0, d}, 16'h0);
    rd(8'h00, d); chk("R8 00h", {8'h0, d}, 16'h0);
    rd16(8'h2E, v); chk("R8 single untouched", v, 16'h5);
    rd16(8'h30, v); chk("R8 multi untouched", v, 16'h2);

    // R5 coherent snapshot: event between high and low reads
    ev(1'b1, 1'b0, 16'h1FF);
    rd(8'h2E, d); chk("R5 high byte", {8'h0, d}, 16'h01);
    ev(1'b1, 1'b0, 1);
    rd(8'h2F, d); chk("R5 low byte from shadow", {8'h0, d}, 16'hFF);
    rd(8'h2F, d); chk("R5 low read repeatable", {8'h0, d}, 16'hFF);
    rd16(8'h2E, v); chk("R5 low read did not clear", v, 16'h1);

    // R6 event on the clearing read
    ev(1'b0, 1'b1, 3);
    mb_evt = 1'b1; rd_en = 1'b1; rd_addr = 8'h30;
    @(negedge clk);
    mb_evt = 1'b0; rd_en = 1'b0;
    chk("R6 high byte", {8'h0, rd_data}, 16'h0);
    rd(8'h31, d); chk("R6 snapshot low", {8'h0, d}, 16'h3);
    rd16(8'h30, v); chk("R6 kept event", v, 16'h1);

    // R7 saturation
    ev(1'b0, 1'b1, 65540);
    rd16(8'h30, v); chk("R7 saturated", v, 16'hFFFF);
    rd16(8'h30, v); chk("R7 cleared after read", v, 16'h0);

    // R1 reset mid-run
    ev(1'b1, 1'b0, 4);
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    rd16(8'h2E, v); chk("R1 reset clears count", v, 16'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule